// File: doc/BRIEF.md
# Waveform Sequencing Timing Engine

This block paces analog output waveform playback. A programmable interval timer emits one-cycle update pulses at a fixed spacing. Each pulse tells the converter to apply the sample already held in its first-stage register. A second counter tracks how many updates make up one buffer, and a third counts how many times that buffer is played. Together the three counters define an output sequence of `updates x repeats` pulses.

The engine keeps the converter's staging register one sample ahead of the pulses. When a run starts, a priming transfer fetches the first sample. After every pulse except the last, the engine fetches the next sample. Each fetch pops the external sample FIFO with a read strobe and then writes that word to the converter. If the FIFO is empty, the fetch waits until data arrives. If a pulse fires while a fetch is still outstanding, the engine records an underrun. When the last buffer repeat completes, pulses stop, `done` rises and `busy` falls.

Top module: `wave_seq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `updatePulse`, `fifoRead`, `dacWrite` and `underrun` are 0 and `underrunCount` is 0.
- R2: With an effective interval N, the first `updatePulse` comes N cycles after the clock edge that accepts `start`, and each later pulse comes exactly N cycles after the one before. An interval value of 0 or 1 gives N = 2.
- R3: A run produces exactly U x B update pulses. U is the updates-per-buffer value and B is the buffer-repeat value, and a value of 0 for either is treated as 1.
- R4: A run makes exactly one priming transfer plus one transfer after each pulse except the final one. Each transfer asserts `fifoRead` for one cycle. In the next cycle, `dacWrite` is high and `dacData` equals the `fifoData` that was present during the read, so samples reach the converter in FIFO order.
- R5: `fifoRead` is never high while `fifoEmpty` is high. A pending transfer waits until `fifoEmpty` goes low, and then it is served.
- R6: `done` rises and `busy` falls in the cycle after the final update pulse. After that, no pulse and no `fifoRead` occur until the next start.
- R7: A `start` that arrives while `busy` is high is ignored. The running sequence keeps its pulse count and timing.
- R8: When an update pulse fires while a transfer is still pending, `underrunCount` increments (saturating) and the sticky flag `underrun` goes high. Both stay set until the next accepted `start` clears them.
- R9: `done` stays high after a run ends and is cleared, with `busy` set, by the edge that accepts the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| cfgInterval | input | 24 | Cycles between update pulses |
| cfgUpdates | input | 24 | Update pulses per buffer |
| cfgRepeats | input | 24 | Number of buffer plays |
| fifoEmpty | input | 1 | Sample FIFO has no data |
| fifoRead | output | 1 | Pop one sample from the FIFO this cycle |
| fifoData | input | 16 | Head-of-FIFO sample, valid while not empty |
| updatePulse | output | 1 | One-cycle converter update strobe |
| dacWrite | output | 1 | Write strobe to the converter staging register |
| dacData | output | 16 | Sample written to the converter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished |
| underrun | output | 1 | Sticky: a pulse found its sample missing |
| underrunCount | output | 8 | Saturating count of underruns |

## Verification
The assertions assume that `fifoData` is valid whenever `fifoEmpty` is low. They also assume that the configuration inputs are only sampled on the edge that accepts `start`, so later changes to them do not matter. The stimulus models the FIFO as an always-available counter sequence, which can be held empty on demand. It changes configuration only at the start edge. It releases an empty hold either before the first pulse, which must cause no underrun, or never, which forces every pulse to underrun.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  // strobes from sequencing control to the sample datapath
  typedef struct packed {
    logic xfer;   // pop FIFO head and stage it for the converter
    logic miss;   // pulse fired while a transfer was outstanding
    logic clear;  // run accepted: reset error state
  } seqStrobe_t;
endpackage

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_seq_pkg::*;
#(
  parameter int INT_W = 24,
  parameter int UPD_W = 24,
  parameter int REP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [INT_W-1:0] cfgInterval,
  input  logic [UPD_W-1:0] cfgUpdates,
  input  logic [REP_W-1:0] cfgRepeats,
  input  logic             fifoEmpty,
  output logic             fifoRead,
  output logic             updatePulse,
  output logic             busy,
  output logic             done,
  output seqStrobe_t       strb
);
  localparam logic [INT_W-1:0] MIN_INT = INT_W'(2);
  localparam logic [UPD_W-1:0] ONE_UPD = UPD_W'(1);
  localparam logic [REP_W-1:0] ONE_REP = REP_W'(1);

  logic             running, doneR, pending;
  logic [INT_W-1:0] intCnt, intReload;
  logic [UPD_W-1:0] updLeft, updReload;
  logic [REP_W-1:0] repLeft;

  logic [INT_W-1:0] effInt;
  logic [UPD_W-1:0] effUpd;
  logic [REP_W-1:0] effRep;
  logic accept, fire, lastInBuf, lastAll, xfer;

  always_comb begin
    effInt    = (cfgInterval < MIN_INT) ? MIN_INT : cfgInterval;
    effUpd    = (cfgUpdates == '0) ? ONE_UPD : cfgUpdates;
    effRep    = (cfgRepeats == '0) ? ONE_REP : cfgRepeats;
    accept    = start && !running;
    fire      = running && (intCnt == '0);
    lastInBuf = (updLeft == ONE_UPD);
    lastAll   = lastInBuf && (repLeft == ONE_REP);
    xfer      = pending && !fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      doneR     <= 1'b0;
      pending   <= 1'b0;
      intCnt    <= '0;
      intReload <= '0;
      updLeft   <= '0;
      updReload <= '0;
      repLeft   <= '0;
    end else if (accept) begin
      running   <= 1'b1;
      doneR     <= 1'b0;
      pending   <= 1'b1;            // priming transfer
      intReload <= effInt - INT_W'(1);
      intCnt    <= effInt - INT_W'(1);
      updReload <= effUpd;
      updLeft   <= effUpd;
      repLeft   <= effRep;
    end else if (running) begin
      intCnt <= fire ? intReload : intCnt - INT_W'(1);
      if (fire && !lastAll) pending <= 1'b1;
      else if (xfer)        pending <= 1'b0;
      if (fire) begin
        if (lastInBuf) begin
          updLeft <= updReload;
          repLeft <= repLeft - REP_W'(1);
        end else begin
          updLeft <= updLeft - UPD_W'(1);
        end
        if (lastAll) begin
          running <= 1'b0;
          doneR   <= 1'b1;
          pending <= 1'b0;
        end
      end
    end
  end

  assign fifoRead    = xfer;
  assign updatePulse = fire;
  assign busy        = running;
  assign done        = doneR;
  assign strb.xfer   = xfer;
  assign strb.miss   = fire && pending;
  assign strb.clear  = accept;

  // R5: never pop an empty FIFO
  a_r5_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifoRead |-> !fifoEmpty);
  // R2: spacing is at least two cycles
  a_r2_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    updatePulse |=> !updatePulse);
  // R4: one read per request; a second needs a fresh pulse
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoRead && !updatePulse) |=> !fifoRead);
  // R6: completion leaves the engine idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(updatePulse)));
  // R7: start while running does not restart the interval
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !updatePulse && intCnt != '0) |=> (intCnt == $past(intCnt) - INT_W'(1)));
endmodule

// File: rtl/wave_seq_dpath.sv
module wave_seq_dpath
  import wave_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] fifoData,
  output logic              dacWrite,
  output logic [DATA_W-1:0] dacData,
  output logic              underrun,
  output logic [ERR_W-1:0]  underrunCount
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dacWrite <= 1'b0;
      dacData  <= '0;
    end else begin
      dacWrite <= strb.xfer;
      if (strb.xfer) dacData <= fifoData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clear) begin
      underrun      <= 1'b0;
      underrunCount <= '0;
    end else if (strb.miss) begin
      underrun <= 1'b1;
      if (underrunCount != ERR_MAX) underrunCount <= underrunCount + ERR_W'(1);
    end
  end

  // R8: flag is sticky until a run is accepted
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !strb.clear) |=> underrun);
  // R8: counter never wraps
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clear && underrunCount == ERR_MAX) |=> underrunCount == ERR_MAX);
endmodule

// File: rtl/wave_seq_engine.sv
module wave_seq_engine
  import wave_seq_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int UPD_W  = 24,
  parameter int REP_W  = 24,
  parameter int DATA_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INT_W-1:0]  cfgInterval,
  input  logic [UPD_W-1:0]  cfgUpdates,
  input  logic [REP_W-1:0]  cfgRepeats,
  input  logic              fifoEmpty,
  output logic              fifoRead,
  input  logic [DATA_W-1:0] fifoData,
  output logic              updatePulse,
  output logic              dacWrite,
  output logic [DATA_W-1:0] dacData,
  output logic              busy,
  output logic              done,
  output logic              underrun,
  output logic [ERR_W-1:0]  underrunCount
);
  seqStrobe_t strb;

  wave_seq_ctrl #(.INT_W(INT_W), .UPD_W(UPD_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgInterval(cfgInterval), .cfgUpdates(cfgUpdates), .cfgRepeats(cfgRepeats),
    .fifoEmpty(fifoEmpty), .fifoRead(fifoRead), .updatePulse(updatePulse),
    .busy(busy), .done(done), .strb(strb)
  );

  wave_seq_dpath #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .fifoData(fifoData),
    .dacWrite(dacWrite), .dacData(dacData),
    .underrun(underrun), .underrunCount(underrunCount)
  );

  // R4: every pop lands in the converter on the next cycle
  a_r4_pop_to_dac: assert property (@(posedge clk) disable iff (!rst_n)
    fifoRead |=> (dacWrite && dacData == $past(fifoData)));
  // R1/R6: no pulses while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !updatePulse);
endmodule

// File: tb/sim_wave_seq_engine.sv
module sim_wave_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] cfgInterval = '0, cfgUpdates = '0, cfgRepeats = '0;
  logic        fifoHold = 1'b0;
  logic        fifoRead, updatePulse, dacWrite, busy, done, underrun;
  logic [15:0] dacData;
  logic [7:0]  underrunCount;
  logic [15:0] rdIdx = '0;
  logic [15:0] fifoData;

  int nRun = 0, nFail = 0;
  int expIdx = 0;

  always #5 clk = ~clk;

  assign fifoData = 16'hA000 + rdIdx;
  always @(posedge clk) if (fifoRead) rdIdx <= rdIdx + 16'd1;

  wave_seq_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgInterval(cfgInterval), .cfgUpdates(cfgUpdates), .cfgRepeats(cfgRepeats),
    .fifoEmpty(fifoHold), .fifoRead(fifoRead), .fifoData(fifoData),
    .updatePulse(updatePulse), .dacWrite(dacWrite), .dacData(dacData),
    .busy(busy), .done(done), .underrun(underrun), .underrunCount(underrunCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {interval, updates, repeats, expected pulses, expected period}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{5, 3, 2, 6, 5},
    '{2, 1, 1, 1, 2},
    '{0, 2, 2, 4, 2},
    '{1, 3, 1, 3, 2},
    '{7, 0, 3, 3, 7},
    '{3, 4, 0, 4, 3}
  };

  int nPulse, firstP, lastP, badGap, doneOff, nDac, dacBad, holdReads, strayPulse;

  // start a run at a negedge and observe until done
  task automatic runSeq(input int iv, input int uv, input int rv,
                        input int holdUntil, input int reAt, input int expN);
    int off;
    cfgInterval = 24'(iv); cfgUpdates = 24'(uv); cfgRepeats = 24'(rv);
    fifoHold = (holdUntil > 0);
    nPulse = 0; firstP = -1; lastP = -1; badGap = 0; doneOff = -1;
    nDac = 0; dacBad = 0; holdReads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    off = 1;
    while (off < 5000) begin
      if (off == 1) begin
        chk(busy == 1'b1, "R9 busy set on accept", int'(busy), 1);
        chk(done == 1'b0, "R9 done cleared on accept", int'(done), 0);
        chk(underrun == 1'b0, "R8 flag cleared on accept", int'(underrun), 0);
      end
      if (fifoHold && fifoRead) holdReads++;
      if (dacWrite) begin
        nDac++;
        if (dacData != 16'(16'hA000 + expIdx)) dacBad++;
        expIdx++;
      end
      if (updatePulse) begin
        nPulse++;
        if (firstP < 0) firstP = off;
        else if (off - lastP != expN) badGap++;
        lastP = off;
      end
      if (done) begin doneOff = off; break; end
      @(negedge clk);
      off++;
      start = (off == reAt);
      if (holdUntil > 0 && off >= holdUntil) fifoHold = 1'b0;
    end
    start = 1'b0;
    fifoHold = 1'b0;
  endtask

  task automatic quietWindow(input int n);
    strayPulse = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (updatePulse || fifoRead || dacWrite) strayPulse++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
    chk(!updatePulse && !fifoRead && !dacWrite, "R1 strobes low",
        int'({updatePulse, fifoRead, dacWrite}), 0);
    chk(!underrun && underrunCount == 0, "R1 error state clear", int'(underrunCount), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven sequences
    for (int v = 0; v < NV; v++) begin
      runSeq(VEC[v][0], VEC[v][1], VEC[v][2], 0, -1, VEC[v][4]);
      chk(nPulse == VEC[v][3], "R3 pulse count", nPulse, VEC[v][3]);
      chk(firstP == VEC[v][4], "R2 first pulse delay", firstP, VEC[v][4]);
      chk(badGap == 0, "R2 pulse spacing", badGap, 0);
      chk(doneOff == lastP + 1, "R6 done after final pulse", doneOff, lastP + 1);
      chk(!busy, "R6 busy cleared", int'(busy), 0);
      chk(nDac == VEC[v][3], "R4 transfer count", nDac, VEC[v][3]);
      chk(dacBad == 0, "R4 samples in FIFO order", dacBad, 0);
      chk(underrunCount == 0, "R8 no underrun when fed", int'(underrunCount), 0);
      quietWindow(2 * VEC[v][4] + 4);
      chk(strayPulse == 0, "R6 quiet after done", strayPulse, 0);
      chk(done, "R9 done holds", int'(done), 1);
    end

    // R8: FIFO held empty for whole run -> every pulse underruns
    runSeq(4, 3, 1, 100000, -1, 4);
    chk(nPulse == 3, "R8 pulses while starved", nPulse, 3);
    chk(holdReads == 0, "R5 no read while empty", holdReads, 0);
    chk(nDac == 0, "R5 nothing written while empty", nDac, 0);
    chk(underrunCount == 3, "R8 underrun count", int'(underrunCount), 3);
    chk(underrun, "R8 sticky flag set", int'(underrun), 1);
    quietWindow(10);
    chk(underrun && underrunCount == 3, "R8 flag persists", int'(underrunCount), 3);
    chk(strayPulse == 0, "R6 no read after done", strayPulse, 0);

    // R5: stall then release before first pulse -> no underrun
    runSeq(8, 2, 1, 4, -1, 8);
    chk(holdReads == 0, "R5 transfer held while empty", holdReads, 0);
    chk(nDac == 2, "R5 held transfer served", nDac, 2);
    chk(dacBad == 0, "R5 sample order after stall", dacBad, 0);
    chk(underrunCount == 0, "R8 no underrun after early release", int'(underrunCount), 0);

    // R7: start while busy is ignored
    runSeq(4, 2, 2, 0, 6, 4);
    chk(nPulse == 4, "R7 pulse count unchanged", nPulse, 4);
    chk(badGap == 0, "R7 spacing unchanged", badGap, 0);
    chk(doneOff == 17, "R7 completion time unchanged", doneOff, 17);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule